// File: doc/BRIEF.md
# Automatic Level Control Gain Engine

This block derives a digital audio gain from the measured loudness of the incoming signal. Each accepted sample carries an unsigned 16-bit magnitude, with full scale equal to 65536. The block produces a signed gain in half-decibel units. Multiplying the audio by that gain happens elsewhere. A 25 µs timebase strobe paces every timed activity. The tests may drive this strobe on every clock to shorten the run.

A loud sample pulls the gain, in unit steps, toward a programmed compressed value over a selectable decay time. The gain then holds. Once the signal has stayed quiet for a selectable hold time, the gain walks back to 0 dB over a selectable attack time. A quiet-threshold crossing during hold or attack restarts the hold timer. A loud sample during attack sends the engine back into decay.

Top module: `alc_gain_engine`

## Requirements
- R1: While `alcEnable` is low, `gainHalfDb` is 0. When `alcEnable` falls, the output is 0 one clock later.
- R2: `gainHalfDb` is two's complement in 0.5 dB units. The compressed target is set by `cmpCode`: 100=+12, 101=+6, 110=0, 111=-6, 000=-12, 001=-18, 010=-24, 011=-30.
- R3: A sample is loud when `sampleValid` is high and `sampleMag` is strictly greater than the high threshold. `highCode` 000..111 selects 39322, 32768, 26214, 19661, 13107, 6554, 3277 or 655. A loud sample in the idle state starts the decay.
- R4: A sample is active when `sampleValid` is high and `sampleMag` is strictly greater than the low threshold. A magnitude equal to the threshold is quiet. `lowCode` 0000..1011 selects 16384, 13107, 9830, 6554, 3277, 1966, 1311, 655, 328, 66, 33 or 7.
- R5: Decay moves the gain one unit toward the target each interval. The interval is the decay duration divided by |target|, rounded down, with a minimum of 1 tick. The first step comes one interval after the loud sample. Durations in ticks: code c below 8 gives c+1; code c of 8 or more gives (c-7)*2000.
- R6: After the gain reaches the target, attack starts only after the hold time has elapsed. `holdCode` 000..111 gives 2000, 4000, 6000, 8000, 40000, 200000, 400000 or 600000 ticks.
- R7: Attack moves the gain one unit toward 0 each interval, using the attack code and the same step count. At 0 the engine becomes idle. A loud sample during attack returns the engine to decay.
- R8: An active sample during hold or attack restarts the hold timer, and the gain stays where it is.
- R9: `lowCode` values 1100..1111 act as threshold 7.
- R10: Without `tick`, no interval or hold time advances and the gain does not change.
- R11: After reset, `gainHalfDb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 25 µs timebase strobe |
| sampleValid | input | 1 | Sample magnitude is valid this cycle |
| sampleMag | input | 16 | Sample magnitude, full scale 65536 |
| alcEnable | input | 1 | Enables gain control |
| cmpCode | input | 3 | Compressed gain select |
| highCode | input | 3 | Loud threshold select |
| lowCode | input | 4 | Quiet threshold select |
| decayCode | input | 4 | Decay duration select |
| attackCode | input | 4 | Attack duration select |
| holdCode | input | 3 | Hold duration select |
| gainHalfDb | output | 7 | Current gain, signed, 0.5 dB units |

## Verification
During attack, a step toward 0 dB and a newly arriving loud or active sample can fall in the same cycle. The new sample must win: the gain does not move that cycle. The engine then enters decay or hold.

The bench provokes this with fast ramps. It lets attack climb to -7 and then injects a loud sample, or a merely active one, in a cycle where a step is due. It judges the outcome by the gain 40 cycles later:
- After the loud sample, decay has run back down to -12.
- After the active sample, the gain is frozen at -7.

A hold-timer expiry that coincides with an active sample is covered the same way. The bench places a restart late in the hold window and checks that recovery is deferred by a full hold period.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int MAG_W          = 16;
  localparam int GAIN_W         = 7;
  localparam int CNT_W          = 20;
  localparam int STEP_W         = 6;
  localparam int TICKS_PER_50MS = 2000;
  localparam logic signed [GAIN_W-1:0] GAIN_MIN = -30;
  localparam logic signed [GAIN_W-1:0] GAIN_MAX = 12;

  typedef enum logic [1:0] {PH_NOMINAL, PH_DECAY, PH_HOLD, PH_ATTACK} phase_t;

  typedef struct packed {
    logic stepGain;
    logic rampAttack;
    logic clrGain;
    logic clrInterval;
    logic clrHold;
  } ctrlStrobes_t;

  typedef struct packed {
    logic loud;
    logic active;
    logic atTarget;
    logic atNominal;
    logic intervalDone;
    logic holdDone;
  } alcStatus_t;

  function automatic logic signed [GAIN_W-1:0] cmpGainHalfDb(input logic [2:0] code);
    case (code)
      3'b100:  return GAIN_W'(12);
      3'b101:  return GAIN_W'(6);
      3'b110:  return GAIN_W'(0);
      3'b111:  return GAIN_W'(-6);
      3'b000:  return GAIN_W'(-12);
      3'b001:  return GAIN_W'(-18);
      3'b010:  return GAIN_W'(-24);
      default: return GAIN_W'(-30);
    endcase
  endfunction

  function automatic logic [MAG_W-1:0] highThreshold(input logic [2:0] code);
    case (code)
      3'd0:    return MAG_W'(39322);
      3'd1:    return MAG_W'(32768);
      3'd2:    return MAG_W'(26214);
      3'd3:    return MAG_W'(19661);
      3'd4:    return MAG_W'(13107);
      3'd5:    return MAG_W'(6554);
      3'd6:    return MAG_W'(3277);
      default: return MAG_W'(655);
    endcase
  endfunction

  function automatic logic [MAG_W-1:0] lowThreshold(input logic [3:0] code);
    case (code)
      4'd0:    return MAG_W'(16384);
      4'd1:    return MAG_W'(13107);
      4'd2:    return MAG_W'(9830);
      4'd3:    return MAG_W'(6554);
      4'd4:    return MAG_W'(3277);
      4'd5:    return MAG_W'(1966);
      4'd6:    return MAG_W'(1311);
      4'd7:    return MAG_W'(655);
      4'd8:    return MAG_W'(328);
      4'd9:    return MAG_W'(66);
      4'd10:   return MAG_W'(33);
      default: return MAG_W'(7);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] rampTicks(input logic [3:0] code);
    if (!code[3]) return CNT_W'(code) + CNT_W'(1);
    return (CNT_W'(code[2:0]) + CNT_W'(1)) * CNT_W'(TICKS_PER_50MS);
  endfunction

  function automatic logic [CNT_W-1:0] holdTicks(input logic [2:0] code);
    case (code)
      3'd0:    return CNT_W'(TICKS_PER_50MS);
      3'd1:    return CNT_W'(2 * TICKS_PER_50MS);
      3'd2:    return CNT_W'(3 * TICKS_PER_50MS);
      3'd3:    return CNT_W'(4 * TICKS_PER_50MS);
      3'd4:    return CNT_W'(20 * TICKS_PER_50MS);
      3'd5:    return CNT_W'(100 * TICKS_PER_50MS);
      3'd6:    return CNT_W'(200 * TICKS_PER_50MS);
      default: return CNT_W'(300 * TICKS_PER_50MS);
    endcase
  endfunction
endpackage

// File: rtl/alc_datapath.sv
module alc_datapath
  import alc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tick,
  input  logic                     sampleValid,
  input  logic [MAG_W-1:0]         sampleMag,
  input  logic [2:0]               cmpCode,
  input  logic [2:0]               highCode,
  input  logic [3:0]               lowCode,
  input  logic [3:0]               decayCode,
  input  logic [3:0]               attackCode,
  input  logic [2:0]               holdCode,
  input  ctrlStrobes_t             ctrl,
  output alcStatus_t               status,
  output logic signed [GAIN_W-1:0] gainQ
);
  logic signed [GAIN_W-1:0] targetGain;
  logic signed [GAIN_W-1:0] rampGoal;
  logic [STEP_W-1:0] stepCount;
  logic [STEP_W-1:0] divisor;
  logic [CNT_W-1:0]  rampLen;
  logic [CNT_W-1:0]  quotient;
  logic [CNT_W-1:0]  intervalTicks;
  logic [CNT_W-1:0]  intervalCnt;
  logic [CNT_W-1:0]  holdCnt;
  logic [CNT_W-1:0]  holdLen;

  assign targetGain = cmpGainHalfDb(cmpCode);
  assign rampGoal   = ctrl.rampAttack ? '0 : targetGain;
  assign holdLen    = holdTicks(holdCode);
  assign rampLen    = rampTicks(ctrl.rampAttack ? attackCode : decayCode);

  // Ramp pacing: the chosen duration is spread over |target| unit steps.
  always_comb begin
    stepCount     = targetGain[GAIN_W-1] ? STEP_W'(-targetGain) : STEP_W'(targetGain);
    divisor       = (stepCount == '0) ? STEP_W'(1) : stepCount;
    quotient      = rampLen / CNT_W'(divisor);
    intervalTicks = (quotient == '0) ? CNT_W'(1) : quotient;
  end

  always_comb begin
    status.loud         = sampleValid && (sampleMag > highThreshold(highCode));
    status.active       = sampleValid && (sampleMag > lowThreshold(lowCode));
    status.atTarget     = (gainQ == targetGain);
    status.atNominal    = (gainQ == '0);
    status.intervalDone = tick && ((intervalCnt + CNT_W'(1)) >= intervalTicks);
    status.holdDone     = (holdCnt >= holdLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (ctrl.clrInterval) begin
      intervalCnt <= '0;
    end else if (tick) begin
      intervalCnt <= status.intervalDone ? '0 : intervalCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (ctrl.clrHold) begin
      holdCnt <= '0;
    end else if (tick && (holdCnt < holdLen)) begin
      holdCnt <= holdCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainQ <= '0;
    end else if (ctrl.clrGain) begin
      gainQ <= '0;
    end else if (ctrl.stepGain) begin
      if (gainQ > rampGoal)      gainQ <= gainQ - GAIN_W'(1);
      else if (gainQ < rampGoal) gainQ <= gainQ + GAIN_W'(1);
    end
  end

  AST_GAIN_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrl.clrGain) |-> (gainQ == $past(gainQ) || gainQ == $past(gainQ) + GAIN_W'(1) ||
                              gainQ == $past(gainQ) - GAIN_W'(1)));  // R5
  AST_GAIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (gainQ >= GAIN_MIN) && (gainQ <= GAIN_MAX));  // R2
  AST_STILL_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !ctrl.clrGain) |=> $stable(gainQ));  // R10
endmodule

// File: rtl/alc_control.sv
module alc_control
  import alc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         alcEnable,
  input  alcStatus_t   status,
  output ctrlStrobes_t ctrl
);
  phase_t phaseQ, phaseNext;

  always_comb begin
    ctrl      = '0;
    phaseNext = phaseQ;
    if (!alcEnable) begin
      phaseNext        = PH_NOMINAL;
      ctrl.clrGain     = 1'b1;
      ctrl.clrInterval = 1'b1;
      ctrl.clrHold     = 1'b1;
    end else begin
      case (phaseQ)
        PH_NOMINAL: begin
          ctrl.clrInterval = 1'b1;
          ctrl.clrHold     = 1'b1;
          if (status.loud) phaseNext = PH_DECAY;
        end
        PH_DECAY: begin
          ctrl.clrHold = 1'b1;
          if (status.atTarget) begin
            phaseNext        = PH_HOLD;
            ctrl.clrInterval = 1'b1;
          end else begin
            ctrl.stepGain = status.intervalDone;
          end
        end
        PH_HOLD: begin
          ctrl.clrInterval = 1'b1;
          if (status.loud || status.active) ctrl.clrHold = 1'b1;
          else if (status.holdDone)         phaseNext    = PH_ATTACK;
        end
        default: begin
          ctrl.rampAttack = 1'b1;
          if (status.loud) begin
            phaseNext        = PH_DECAY;
            ctrl.clrInterval = 1'b1;
          end else if (status.active) begin
            phaseNext        = PH_HOLD;
            ctrl.clrInterval = 1'b1;
            ctrl.clrHold     = 1'b1;
          end else if (status.atNominal) begin
            phaseNext = PH_NOMINAL;
          end else begin
            ctrl.stepGain = status.intervalDone;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PH_NOMINAL;
    else       phaseQ <= phaseNext;
  end

  AST_DISABLE_TO_NOMINAL: assert property (@(posedge clk) disable iff (!rstN)
    !alcEnable |=> (phaseQ == PH_NOMINAL));  // R1
  AST_ATTACK_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_ATTACK && $past(phaseQ) == PH_HOLD) |-> $past(status.holdDone));  // R6
  AST_LOUD_ABORTS_ATTACK: assert property (@(posedge clk) disable iff (!rstN)
    (alcEnable && phaseQ == PH_ATTACK && status.loud) |=> (phaseQ == PH_DECAY));  // R7
  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_NOMINAL) |-> status.atNominal);  // R7
endmodule

// File: rtl/alc_gain_engine.sv
module alc_gain_engine
  import alc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tick,
  input  logic                     sampleValid,
  input  logic [MAG_W-1:0]         sampleMag,
  input  logic                     alcEnable,
  input  logic [2:0]               cmpCode,
  input  logic [2:0]               highCode,
  input  logic [3:0]               lowCode,
  input  logic [3:0]               decayCode,
  input  logic [3:0]               attackCode,
  input  logic [2:0]               holdCode,
  output logic signed [GAIN_W-1:0] gainHalfDb
);
  ctrlStrobes_t ctrl;
  alcStatus_t   status;

  alc_control u_control (
    .clk(clk), .rstN(rstN), .alcEnable(alcEnable), .status(status), .ctrl(ctrl)
  );

  alc_datapath u_datapath (
    .clk(clk), .rstN(rstN), .tick(tick), .sampleValid(sampleValid), .sampleMag(sampleMag),
    .cmpCode(cmpCode), .highCode(highCode), .lowCode(lowCode), .decayCode(decayCode),
    .attackCode(attackCode), .holdCode(holdCode), .ctrl(ctrl), .status(status),
    .gainQ(gainHalfDb)
  );
endmodule

// File: tb/sim_alc_gain_engine.sv
module sim_alc_gain_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1;
  logic sampleValid = 1'b0;
  logic [15:0] sampleMag = '0;
  logic alcEnable = 1'b1;
  logic [2:0] cmpCode = 3'b111;
  logic [2:0] highCode = 3'b000;
  logic [3:0] lowCode = 4'b0000;
  logic [3:0] decayCode = 4'b0000;
  logic [3:0] attackCode = 4'b0000;
  logic [2:0] holdCode = 3'b000;
  logic signed [6:0] gain;

  int compared = 0;
  int mismatched = 0;
  int relK = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  alc_gain_engine u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .sampleValid(sampleValid), .sampleMag(sampleMag),
    .alcEnable(alcEnable), .cmpCode(cmpCode), .highCode(highCode), .lowCode(lowCode),
    .decayCode(decayCode), .attackCode(attackCode), .holdCode(holdCode), .gainHalfDb(gain)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic configure(input logic [2:0] cmp, input logic [2:0] high, input logic [3:0] low,
                           input logic [3:0] dec, input logic [3:0] att, input logic [2:0] hold);
    cmpCode = cmp; highCode = high; lowCode = low;
    decayCode = dec; attackCode = att; holdCode = hold;
  endtask

  task automatic clearEngine();
    @(negedge clk); alcEnable = 1'b0;
    @(negedge clk); @(negedge clk); alcEnable = 1'b1;
  endtask

  // sample consumed at edge E0; relK counts edges since then
  task automatic startRun(input int mag);
    sampleValid = 1'b1; sampleMag = 16'(mag);
    @(negedge clk); relK = 0; sampleValid = 1'b0;
  endtask

  task automatic advanceTo(input int k);
    while (relK < k) begin @(negedge clk); relK++; end
  endtask

  task automatic pulse(input int k, input int mag);
    advanceTo(k - 1);
    sampleValid = 1'b1; sampleMag = 16'(mag);
    @(negedge clk); relK = k; sampleValid = 1'b0;
  endtask

  task automatic testReset();
    check("R11 gain after reset", int'(gain), 0);
  endtask

  task automatic testDisabled();
    configure(3'b000, 3'b000, 4'b0000, 4'd0, 4'd0, 3'd0);
    @(negedge clk); alcEnable = 1'b0;
    startRun(40000); advanceTo(50);
    check("R1 loud sample while disabled", int'(gain), 0);
    alcEnable = 1'b1;
  endtask

  task automatic testFullCycle();
    clearEngine();
    configure(3'b000, 3'b000, 4'b0000, 4'd8, 4'd8, 3'd0);
    startRun(40000);
    advanceTo(1000); check("R5 slow decay midway", int'(gain), -6);
    advanceTo(2100); check("R5 slow decay reaches target", int'(gain), -12);
    advanceTo(3000); check("R6 gain held during hold time", int'(gain), -12);
    advanceTo(4500); check("R7 slow attack midway", int'(gain), -9);
    advanceTo(6200); check("R7 attack back to nominal", int'(gain), 0);
  endtask

  task automatic testFastDecay();
    clearEngine();
    configure(3'b011, 3'b000, 4'b0000, 4'd0, 4'd0, 3'd0);
    startRun(40000);
    advanceTo(10); check("R5 one-tick minimum interval", int'(gain), -10);
    advanceTo(40); check("R2 code 011 target -30", int'(gain), -30);
  endtask

  task automatic testPositive();
    clearEngine();
    configure(3'b100, 3'b000, 4'b0000, 4'd0, 4'd0, 3'd0);
    startRun(40000);
    advanceTo(5);  check("R5 upward ramp midway", int'(gain), 5);
    advanceTo(20); check("R2 code 100 target +12", int'(gain), 12);
  endtask

  task automatic thresholdRun(input logic [2:0] high, input int mag, input int exp, input string tag);
    clearEngine();
    configure(3'b111, high, 4'b0000, 4'd0, 4'd0, 3'd0);
    startRun(mag); advanceTo(20);
    check(tag, int'(gain), exp);
  endtask

  task automatic holdProbe(input logic [3:0] low, input int mag, input int exp, input string tag);
    clearEngine();
    configure(3'b000, 3'b000, low, 4'd0, 4'd0, 3'd0);
    startRun(40000);
    pulse(1500, mag);
    advanceTo(2100); check(tag, int'(gain), exp);
    advanceTo(3700); check({tag, " final recovery"}, int'(gain), 0);
  endtask

  task automatic testAttackInterrupt(input int mag, input int exp, input string tag);
    clearEngine();
    configure(3'b000, 3'b000, 4'b0000, 4'd0, 4'd0, 3'd0);
    startRun(40000);
    advanceTo(2019); check("R7 attack partly done", int'(gain), -7);
    pulse(2020, mag);
    advanceTo(2060); check(tag, int'(gain), exp);
  endtask

  task automatic testTickGate();
    clearEngine();
    configure(3'b000, 3'b000, 4'b0000, 4'd0, 4'd0, 3'd0);
    tick = 1'b0;
    startRun(40000);
    advanceTo(100); check("R10 no progress without tick", int'(gain), 0);
    tick = 1'b1;
    advanceTo(110); check("R10 progress resumes with tick", int'(gain), -10);
  endtask

  task automatic testDisableMid();
    clearEngine();
    configure(3'b000, 3'b000, 4'b0000, 4'd0, 4'd0, 3'd0);
    startRun(40000);
    advanceTo(100); check("R1 compressed before disable", int'(gain), -12);
    alcEnable = 1'b0;
    advanceTo(101); check("R1 disable returns gain to 0", int'(gain), 0);
    alcEnable = 1'b1;
  endtask

  task automatic testLongHold();
    clearEngine();
    configure(3'b000, 3'b000, 4'b0000, 4'd0, 4'd0, 3'd4);
    startRun(40000);
    advanceTo(39900); check("R6 one-second hold still compressed", int'(gain), -12);
    advanceTo(40100); check("R6 recovery after one-second hold", int'(gain), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabled();
    testFullCycle();
    testFastDecay();
    testPositive();
    thresholdRun(3'b111, 655, 0, "R3 equal to 0.01 threshold is not loud");
    thresholdRun(3'b111, 656, -6, "R3 above 0.01 threshold is loud");
    thresholdRun(3'b000, 39322, 0, "R3 equal to 0.6 threshold is not loud");
    thresholdRun(3'b000, 39323, -6, "R3 above 0.6 threshold is loud");
    holdProbe(4'b0000, 16384, 0, "R4 sample equal to low threshold is quiet");
    holdProbe(4'b0000, 20000, -12, "R8 active sample restarts hold");
    holdProbe(4'b1100, 7, 0, "R9 reserved code threshold 7 equal is quiet");
    holdProbe(4'b1100, 8, -12, "R9 reserved code threshold 7 exceeded");
    testAttackInterrupt(40000, -12, "R7 loud sample during attack redoes decay");
    testAttackInterrupt(20000, -7, "R8 active sample during attack freezes gain");
    testTickGate();
    testDisableMid();
    testLongHold();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule